// File: doc/BRIEF.md
# Class-D Channel Startup Sequencer

This block sequences four PWM power-stage output lanes, grouped as pair A (lanes 0 and 1) and pair B (lanes 2 and 3). Each pair has its own active-low enable. A 3-bit mode code selects which lanes have their PWM input inverted internally and which pairs may run a soft ramp. For every lane the block produces a drive enable, a high-impedance flag, a ramp-activity flag and the gated PWM value for the gate driver.

After its pair is enabled, a lane stays high impedance until its own synchronised PWM input goes from low to high. Where ramping is allowed, enabling a pair walks a digital level counter up to a full-scale count. Disabling the pair walks it back down. A lane may drive only once the ramp has reached full scale. A per-pair force-off input from a separate protection block overrides every other state. The ramp level of each pair is visible on output ports.

Top module: `classd_start_seq`

## Requirements
- R1: While `pair_rst_n[p]` is low, both lanes of pair p have `drive_en` low in the same cycle, and the recorded input edge is cleared.
- R2: With no ramp, a lane drives only after its own input rises. `drive_en[i]` goes high after the third rising clock edge following the input change (two synchroniser flops plus the edge record). Lanes are gated independently, and `pwm_out[i]` is low whenever `drive_en[i]` is low.
- R3: An input held high through the release of the pair enable does not count as an edge. The input must first be seen low and then high.
- R4: Once recorded, an edge stays recorded until the pair enable goes low. The lane keeps driving and follows its input when the input later falls.
- R5: `pwm_out` is the synchronised input XOR a mode mask. Mode 100 inverts lanes 1 and 3, mode 101 inverts lane 3, and mode 110 inverts lanes 2 and 3. Every other mode passes the inputs through unchanged.
- R6: With `ramp_en` high, mode 011 ramps both pairs, and modes 001 and 101 ramp pair A only. In all other modes nothing ramps, the levels stay 0, and lanes of a non-ramping pair do not wait for a ramp.
- R7: On release of a ramping pair, its level rises by one per clock up to `RAMP_CYCLES`. `ramp_act` is high for the pair's lanes while the level moves. `drive_en` is held low until the level is full, even if an edge came earlier.
- R8: If no edge was recorded by the end of a ramp-up, the lane goes high impedance and drives after a later edge.
- R9: Pulling a ramping pair's enable low moves its level down by one per clock to 0. During that descent `ramp_act` is high and `hiz` is low. A new release reverses the direction from the current level.
- R10: An active `fault_off[p]` forces both lanes of pair p to `hiz` high, with `drive_en` and `ramp_act` low, in the same cycle.
- R11: In mode 111 all four lanes are high impedance.
- R12: A pair's level never exceeds `RAMP_CYCLES`, changes by at most one per clock, and saturates at full scale.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Power-on reset, active low, clears all state |
| pair_rst_n | input | 2 | Pair enables, active low; bit 0 is lanes 0/1, bit 1 is lanes 2/3 |
| mode | input | 3 | Output mode code |
| ramp_en | input | 1 | Allows soft ramping in eligible modes |
| pwm_in | input | 4 | Asynchronous PWM inputs, one per lane |
| fault_off | input | 2 | Per-pair force-off from protection logic |
| pwm_out | output | 4 | Gated and mode-inverted PWM for each lane |
| drive_en | output | 4 | Lane is actively switching |
| hiz | output | 4 | Lane is high impedance |
| ramp_act | output | 4 | Lane is following a moving ramp |
| level_a | output | LVL_W | Ramp level of pair A, 0 to RAMP_CYCLES |
| level_b | output | LVL_W | Ramp level of pair B, 0 to RAMP_CYCLES |

## Verification
The bench builds the block with `RAMP_CYCLES` set to 12 and the default two synchroniser stages. This makes a full ramp-up, a ramp-down that is reversed partway, and saturation at full scale each last only a dozen cycles. Within that span the bench can count exact levels, compare an edge arriving mid-ramp against one arriving after it, and run every mode code, including the reserved one.

// File: rtl/classd_seq_pkg.sv
package classd_seq_pkg;

  localparam int NUM_LANE = 4;
  localparam int NUM_PAIR = 2;

  typedef enum logic [2:0] {
    M_FB_DUAL       = 3'b000,
    M_HB2_FB1       = 3'b001,
    M_FB_PAR        = 3'b010,
    M_HB_QUAD       = 3'b011,
    M_FB_DUAL_INV   = 3'b100,
    M_HB2_FB1_INV   = 3'b101,
    M_FB_PAR_INV    = 3'b110,
    M_RESERVED      = 3'b111
  } out_mode_e;

  function automatic logic [NUM_LANE-1:0] lane_invert(input logic [2:0] m);
    case (out_mode_e'(m))
      M_FB_DUAL_INV: return 4'b1010;
      M_HB2_FB1_INV: return 4'b1000;
      M_FB_PAR_INV:  return 4'b1100;
      default:       return 4'b0000;
    endcase
  endfunction

  function automatic logic pair_may_ramp(input logic [2:0] m, input int pair);
    if (pair == 0)
      return (out_mode_e'(m) == M_HB2_FB1) || (out_mode_e'(m) == M_HB_QUAD) ||
             (out_mode_e'(m) == M_HB2_FB1_INV);
    return out_mode_e'(m) == M_HB_QUAD;
  endfunction

  function automatic logic mode_reserved(input logic [2:0] m);
    return out_mode_e'(m) == M_RESERVED;
  endfunction

endpackage

// File: rtl/classd_seq_sync.sv
module classd_seq_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dsync,
  output logic [WIDTH-1:0] rise
);

  logic [WIDTH-1:0] chain [STAGES];
  logic [WIDTH-1:0] last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) chain[k] <= '0;
      last <= '0;
    end else begin
      chain[0] <= din;
      for (int k = 1; k < STAGES; k++) chain[k] <= chain[k-1];
      last <= chain[STAGES-1];
    end
  end

  assign dsync = chain[STAGES-1];
  assign rise  = chain[STAGES-1] & ~last;

endmodule

// File: rtl/classd_seq_ramp.sv
module classd_seq_ramp #(
  parameter int FULL = 4096,
  parameter int LW   = $clog2(FULL + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          raise,
  output logic [LW-1:0] level,
  output logic          busy,
  output logic          at_full
);

  localparam logic [LW-1:0] TOP = LW'(FULL);

  function automatic logic [LW-1:0] step_toward(input logic [LW-1:0] cur, input logic up);
    if (up)  return (cur != TOP) ? cur + LW'(1) : cur;
    return (cur != '0) ? cur - LW'(1) : cur;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level <= '0;
    else        level <= step_toward(level, raise);
  end

  assign at_full = (level == TOP);
  assign busy    = raise ? (level != TOP) : (level != '0);

endmodule

// File: rtl/classd_seq_lane.sv
module classd_seq_lane (
  input  logic clk,
  input  logic rst_n,
  input  logic pair_rel,
  input  logic force_off,
  input  logic rise,
  input  logic din_sync,
  input  logic invert,
  input  logic ramp_on,
  input  logic ramp_full,
  input  logic ramp_busy,
  output logic drive_en,
  output logic hiz,
  output logic ramp_act,
  output logic pout,
  output logic armed
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          armed <= 1'b0;
    else if (!pair_rel)  armed <= 1'b0;
    else if (rise)       armed <= 1'b1;
  end

  assign drive_en = pair_rel && !force_off && armed && (!ramp_on || ramp_full);
  assign ramp_act = ramp_on && ramp_busy && !force_off;
  assign hiz      = !drive_en && !ramp_act;
  assign pout     = drive_en && (din_sync ^ invert);

endmodule

// File: rtl/classd_start_seq.sv
module classd_start_seq
  import classd_seq_pkg::*;
#(
  parameter int RAMP_CYCLES = 4096,
  parameter int SYNC_STAGES = 2,
  localparam int LVL_W = $clog2(RAMP_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       pair_rst_n,
  input  logic [2:0]       mode,
  input  logic             ramp_en,
  input  logic [3:0]       pwm_in,
  input  logic [1:0]       fault_off,
  output logic [3:0]       pwm_out,
  output logic [3:0]       drive_en,
  output logic [3:0]       hiz,
  output logic [3:0]       ramp_act,
  output logic [LVL_W-1:0] level_a,
  output logic [LVL_W-1:0] level_b
);

  // Named internal events, brought out for the checker
  logic [NUM_LANE-1:0] sync_in;
  logic [NUM_LANE-1:0] edge_rise;
  logic [NUM_LANE-1:0] armed;
  logic [NUM_LANE-1:0] inv_mask;
  logic [NUM_PAIR-1:0] pair_ramp_on;
  logic [NUM_PAIR-1:0] pair_full;
  logic [NUM_PAIR-1:0] pair_busy;
  logic [NUM_PAIR-1:0] pair_force;
  logic [LVL_W-1:0]    pair_level [NUM_PAIR];
  logic                rsvd;

  assign inv_mask = lane_invert(mode);
  assign rsvd     = mode_reserved(mode);

  classd_seq_sync #(.WIDTH(NUM_LANE), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (pwm_in),
    .dsync (sync_in),
    .rise  (edge_rise)
  );

  for (genvar p = 0; p < NUM_PAIR; p++) begin : g_pair
    assign pair_ramp_on[p] = ramp_en && pair_may_ramp(mode, p);
    assign pair_force[p]   = fault_off[p] || rsvd;

    classd_seq_ramp #(.FULL(RAMP_CYCLES), .LW(LVL_W)) u_ramp (
      .clk     (clk),
      .rst_n   (rst_n),
      .raise   (pair_rst_n[p] && pair_ramp_on[p]),
      .level   (pair_level[p]),
      .busy    (pair_busy[p]),
      .at_full (pair_full[p])
    );
  end

  for (genvar i = 0; i < NUM_LANE; i++) begin : g_lane
    localparam int P = i / 2;
    classd_seq_lane u_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .pair_rel  (pair_rst_n[P]),
      .force_off (pair_force[P]),
      .rise      (edge_rise[i]),
      .din_sync  (sync_in[i]),
      .invert    (inv_mask[i]),
      .ramp_on   (pair_ramp_on[P]),
      .ramp_full (pair_full[P]),
      .ramp_busy (pair_busy[P]),
      .drive_en  (drive_en[i]),
      .hiz       (hiz[i]),
      .ramp_act  (ramp_act[i]),
      .pout      (pwm_out[i]),
      .armed     (armed[i])
    );
  end

  assign level_a = pair_level[0];
  assign level_b = pair_level[1];

endmodule

// File: rtl/classd_start_seq_chk.sv
module classd_start_seq_chk #(
  parameter int RAMP_CYCLES = 4096,
  parameter int LVL_W = 13
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       pair_rst_n,
  input logic [2:0]       mode,
  input logic [1:0]       fault_off,
  input logic [3:0]       drive_en,
  input logic [3:0]       hiz,
  input logic [3:0]       ramp_act,
  input logic [3:0]       armed,
  input logic [1:0]       pair_ramp_on,
  input logic [LVL_W-1:0] level_a,
  input logic [LVL_W-1:0] level_b
);

  localparam logic [LVL_W-1:0] TOP = LVL_W'(RAMP_CYCLES);

  logic [LVL_W-1:0] lv [2];
  assign lv[0] = level_a;
  assign lv[1] = level_b;

  for (genvar p = 0; p < 2; p++) begin : g_pchk
    assert_level_max_R12: assert property (@(posedge clk) disable iff (!rst_n)
      lv[p] <= TOP);
    assert_level_step_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (lv[p] != $past(lv[p])) |-> ((lv[p] == $past(lv[p]) + LVL_W'(1)) ||
                                   (lv[p] + LVL_W'(1) == $past(lv[p]))));
  end

  for (genvar i = 0; i < 4; i++) begin : g_lchk
    localparam int P = i / 2;
    assert_pair_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !pair_rst_n[P] |-> !drive_en[i]);
    assert_drive_needs_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
      drive_en[i] |-> armed[i]);
    assert_edge_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (armed[i] && pair_rst_n[P]) |=> (armed[i] || !pair_rst_n[P]));
    assert_ramp_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (drive_en[i] && pair_ramp_on[P]) |-> (lv[P] == TOP));
    assert_off_hiz_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!pair_rst_n[P] && !ramp_act[i]) |-> hiz[i]);
    assert_fault_hiz_R10: assert property (@(posedge clk) disable iff (!rst_n)
      fault_off[P] |-> (hiz[i] && !drive_en[i] && !ramp_act[i]));
    assert_reserved_hiz_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 3'b111) |-> hiz[i]);
  end

endmodule

bind classd_start_seq classd_start_seq_chk #(
  .RAMP_CYCLES (RAMP_CYCLES),
  .LVL_W       (LVL_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .pair_rst_n   (pair_rst_n),
  .mode         (mode),
  .fault_off    (fault_off),
  .drive_en     (drive_en),
  .hiz          (hiz),
  .ramp_act     (ramp_act),
  .armed        (armed),
  .pair_ramp_on (pair_ramp_on),
  .level_a      (level_a),
  .level_b      (level_b)
);

// File: tb/classd_start_seq_bench.sv
module classd_start_seq_bench;

  localparam int RC = 12;
  localparam int LW = $clog2(RC + 1);

  logic          clk = 1'b0;
  logic          rst_n;
  logic [1:0]    pair_rst_n;
  logic [2:0]    mode;
  logic          ramp_en;
  logic [3:0]    pwm_in;
  logic [1:0]    fault_off;
  logic [3:0]    pwm_out, drive_en, hiz, ramp_act;
  logic [LW-1:0] level_a, level_b;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  classd_start_seq #(.RAMP_CYCLES(RC), .SYNC_STAGES(2)) u_classd_start_seq (
    .clk(clk), .rst_n(rst_n), .pair_rst_n(pair_rst_n), .mode(mode),
    .ramp_en(ramp_en), .pwm_in(pwm_in), .fault_off(fault_off),
    .pwm_out(pwm_out), .drive_en(drive_en), .hiz(hiz), .ramp_act(ramp_act),
    .level_a(level_a), .level_b(level_b)
  );

  function automatic logic [3:0] want_inv(input logic [2:0] m);
    logic b1, b2, b3;
    b1 = (m == 3'd4);
    b2 = (m == 3'd6);
    b3 = (m == 3'd4) || (m == 3'd5) || (m == 3'd6);
    return {b3, b2, b1, 1'b0};
  endfunction

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #2;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic quiesce();
    pair_rst_n = 2'b00;
    fault_off  = 2'b00;
    pwm_in     = 4'h0;
    step(RC + 3);
  endtask

  task automatic t_reset_state();
    rst_n = 1'b0; pair_rst_n = 2'b00; mode = 3'd0; ramp_en = 1'b0;
    pwm_in = 4'h0; fault_off = 2'b00;
    step(3);
    chk("R1 reset hiz", hiz, 4'hF);
    chk("R1 reset drive", drive_en, 4'h0);
    chk("R1 reset levels", {level_b, level_a}, 0);
    rst_n = 1'b1;
    step(2);
    chk("R1 pairs held hiz", hiz, 4'hF);
  endtask

  task automatic t_gate();
    mode = 3'd0; ramp_en = 1'b0;
    pair_rst_n = 2'b11;
    step(5);
    chk("R2 no edge yet", hiz, 4'hF);
    pwm_in = 4'b0001;
    step(2);
    chk("R2 latency not yet", drive_en, 4'h0);
    step(1);
    chk("R2 lane0 drives", drive_en, 4'b0001);
    chk("R2 others hiz", hiz, 4'b1110);
    chk("R2 pwm_out follows", pwm_out, 4'b0001);
    pwm_in = 4'b0000;
    step(2);
    chk("R4 still driving", drive_en, 4'b0001);
    chk("R4 output follows low", pwm_out, 4'b0000);
    pwm_in = 4'b0100;
    step(3);
    chk("R2 independent lane2", drive_en, 4'b0101);
  endtask

  task automatic t_reset_clear();
    pair_rst_n = 2'b10;
    #1;
    chk("R1 pair A off at once", drive_en, 4'b0100);
    chk("R1 pair A hiz", hiz, 4'b1011);
    pwm_in = 4'b0101;
    step(3);
    pair_rst_n = 2'b11;
    step(5);
    chk("R3 held-high input ignored", {hiz[0], drive_en[0]}, 2'b10);
    pwm_in = 4'b0100;
    step(3);
    pwm_in = 4'b0101;
    step(3);
    chk("R3 fresh edge accepted", drive_en, 4'b0101);
  endtask

  task automatic t_invert();
    logic [2:0] list [7] = '{3'd0, 3'd4, 3'd5, 3'd6, 3'd1, 3'd2, 3'd3};
    ramp_en = 1'b0;
    for (int k = 0; k < 7; k++) begin
      quiesce();
      mode = list[k];
      pair_rst_n = 2'b11;
      step(2);
      pwm_in = 4'hF;
      step(3);
      chk("R5 all driving", drive_en, 4'hF);
      chk("R5 high pattern", pwm_out, 4'hF ^ want_inv(list[k]));
      pwm_in = 4'h0;
      step(2);
      chk("R5 low pattern", pwm_out, want_inv(list[k]));
    end
  endtask

  task automatic t_ramp_up();
    quiesce();
    mode = 3'd3; ramp_en = 1'b1;
    pair_rst_n = 2'b11;
    step(1);
    chk("R7 first step", {level_b, level_a}, {LW'(1), LW'(1)});
    chk("R7 ramp active", ramp_act, 4'hF);
    chk("R7 ramping not hiz", hiz, 4'h0);
    step(2);
    pwm_in = 4'b0001;
    step(RC - 4);
    chk("R7 level before full", level_a, RC - 1);
    chk("R7 edge waits for ramp", drive_en, 4'h0);
    step(1);
    chk("R7 drive at full", drive_en, 4'b0001);
    chk("R8 ramp done", ramp_act, 4'h0);
    chk("R8 no edge goes hiz", hiz, 4'b1110);
    step(3);
    chk("R12 level saturates", level_a, RC);
    pwm_in = 4'b0011;
    step(3);
    chk("R8 late edge drives", drive_en, 4'b0011);
  endtask

  task automatic t_ramp_down();
    pair_rst_n = 2'b10;
    #1;
    chk("R9 drive off", drive_en, 4'h0);
    chk("R9 descent active", ramp_act, 4'b0011);
    chk("R9 descent not hiz", hiz, 4'b1100);
    step(5);
    chk("R9 level falling", level_a, RC - 5);
    pair_rst_n = 2'b11;
    step(2);
    chk("R9 reversal", level_a, RC - 3);
    chk("R9 rising again", ramp_act[1:0], 2'b11);
    pair_rst_n = 2'b10;
    step(RC + 1);
    chk("R9 reached ground", level_a, 0);
    chk("R9 idle hiz", hiz, 4'hF);
    chk("R9 idle no ramp", ramp_act, 4'h0);
  endtask

  task automatic t_partial();
    ramp_en = 1'b1;
    quiesce();
    mode = 3'd1;
    pair_rst_n = 2'b11;
    step(3);
    chk("R6 pair A ramps", level_a, 3);
    chk("R6 pair B stays", level_b, 0);
    chk("R6 ramp lanes", ramp_act, 4'b0011);
    pwm_in = 4'b0101;
    step(3);
    chk("R6 pair B no wait", drive_en, 4'b0100);
    step(RC - 6);
    chk("R7 pair A after ramp", drive_en, 4'b0101);
    quiesce();
    mode = 3'd0;
    pair_rst_n = 2'b11;
    step(3);
    chk("R6 full-bridge no ramp", {level_b, level_a, ramp_act}, 0);
  endtask

  task automatic t_fault();
    ramp_en = 1'b0;
    quiesce();
    mode = 3'd3;
    pair_rst_n = 2'b11;
    step(2);
    pwm_in = 4'hF;
    step(3);
    chk("R10 armed first", drive_en, 4'hF);
    fault_off = 2'b10;
    #1;
    chk("R10 pair B hiz", hiz, 4'b1100);
    chk("R10 pair A kept", drive_en, 4'b0011);
    chk("R10 outputs", pwm_out, 4'b0011);
    ramp_en = 1'b1;
    quiesce();
    pair_rst_n = 2'b11;
    step(2);
    fault_off = 2'b01;
    #1;
    chk("R10 ramp overridden", ramp_act, 4'b1100);
    chk("R10 ramp lane hiz", hiz, 4'b0011);
    fault_off = 2'b00;
  endtask

  task automatic t_reserved();
    ramp_en = 1'b0;
    quiesce();
    mode = 3'd7;
    pair_rst_n = 2'b11;
    step(2);
    pwm_in = 4'hF;
    step(4);
    chk("R11 reserved hiz", hiz, 4'hF);
    chk("R11 reserved no drive", {drive_en, pwm_out}, 0);
  endtask

  initial begin
    t_reset_state();
    t_gate();
    t_reset_clear();
    t_invert();
    t_ramp_up();
    t_ramp_down();
    t_partial();
    t_fault();
    t_reserved();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule